// File: doc/BRIEF.md
# Rising-Edge Sawtooth Phase Detector

This block compares the phase of a reference square wave with a feedback square wave, both asynchronous to the system clock. Each input is brought into the system clock domain and reduced to a single-cycle rising-edge pulse. A single state bit is set by a reference edge and cleared by a feedback edge. The fraction of each reference period that this bit spends high is therefore proportional to the phase lag of the feedback, and the response stays linear across a full cycle. Only rising edges matter, so the duty cycle of either input has no effect on the result.

A measuring stage counts system clocks over each reference period and counts the clocks for which the state bit is high. On every reference edge it publishes a signed error word equal to the high count minus half the period count, with a one-cycle valid strobe. Against phase lag the word rises linearly and falls abruptly where the lag wraps past a full period, which is the sawtooth characteristic. The state bit is also available raw, for an external averaging filter.

Top module: `phase_sawtooth_det`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it goes high, `state_o` is 0, `err_vld_o` is 0 and `err_o` is 0.
- R2: A rising edge on `ref_i` sets `state_o` and a rising edge on `fb_i` clears it. Each change appears at the third rising clock edge after the input changes (two synchronizer stages plus the state register).
- R3: When the two rising edges are detected in the same system clock cycle, `state_o` is cleared or stays low, so a zero-lag pair never drives the state high.
- R4: `err_o` is a two's-complement word of CW+1 bits equal to H - floor(P/2), where P is the number of clocks between the last two detected reference edges and H is the number of those clocks in which the state was high.
- R5: `err_vld_o` is high for exactly one cycle per detected reference edge, except the first reference edge after reset, which produces no strobe. `err_o` holds its value between strobes.
- R6: The high width of either input, at a fixed edge lag, does not change `err_o`.
- R7: With the feedback edge lagging the reference edge by D clocks and period P, the word is D - floor(P/2) for 0 <= D < P. A lag of P+1 clocks yields the same word as a lag of 1, which is the sawtooth wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference square wave, asynchronous |
| fb_i | input | 1 | Feedback square wave, asynchronous |
| state_o | output | 1 | Raw detector state bit |
| err_o | output | CW+1 | Signed phase-error word |
| err_vld_o | output | 1 | One-cycle strobe when `err_o` is updated |

## Verification
A wrong state bit shows at `state_o` three clocks after the edge that caused it. It also corrupts the high count, so `err_o` moves away from D - P/2 at the very next strobe. A miscounted period shifts the word by half the error on the strobe that ends that period. A stuck or doubled strobe, or a strobe on the first edge after reset, is caught by counting strobes against the reference edges that were driven. Lags of zero and of one clock past the period are driven on purpose, so a wrong tie rule or a wrong wrap shows as a word of the wrong sign.

// File: rtl/phd_pkg.sv
package phd_pkg;

    // Rising-edge pulses of both inputs in the system clock domain.
    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/phd_edge_sync.sv
module phd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic rise_o
);

    localparam int unsigned W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[W-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R6

endmodule

// File: rtl/phd_state.sv
module phd_state
    import phd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  edge_pair_t edges_i,
    output logic       state_o
);

    typedef struct packed {
        logic hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edges_i.fb_rise)       st_d.hold = 1'b0;
        else if (edges_i.ref_rise) st_d.hold = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign state_o = st_q.hold;

    AST_SET_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_i.ref_rise && !edges_i.fb_rise) |=> state_o); // R2
    AST_CLEAR_ON_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_i.fb_rise && !edges_i.ref_rise) |=> !state_o); // R2
    AST_TIE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_i.fb_rise && edges_i.ref_rise) |=> !state_o); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edges_i.fb_rise && !edges_i.ref_rise) |=> $stable(state_o)); // R2

endmodule

// File: rtl/phd_meter.sv
module phd_meter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ref_rise_i,
    input  logic          state_i,
    output logic [CW:0]   err_o,
    output logic          err_vld_o
);

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] per;
        logic [CW-1:0] hi;
        logic          seen;
        logic [CW:0]   word;
        logic          vld;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic [CW:0] high_cnt;
    logic [CW:0] per_cnt;
    logic [CW:0] diff;

    always_comb begin
        high_cnt = {1'b0, st_q.hi} + {{CW{1'b0}}, state_i};
        per_cnt  = {1'b0, st_q.per} + {{CW{1'b0}}, 1'b1};
        diff     = high_cnt - (per_cnt >> 1);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (ref_rise_i) begin
            st_d.per  = '0;
            st_d.hi   = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.word = diff;
                st_d.vld  = 1'b1;
            end
        end else begin
            if (st_q.per != CMAX)            st_d.per = st_q.per + 1'b1;
            if (state_i && st_q.hi != CMAX)  st_d.hi  = st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_o     = st_q.word;
    assign err_vld_o = st_q.vld;

    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_vld_o |=> !err_vld_o); // R5
    AST_FIRST_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_rise_i && !st_q.seen) |=> !err_vld_o); // R5
    AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ref_rise_i |=> $stable(err_o)); // R5
    AST_HIGH_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.hi <= st_q.per); // R4

endmodule

// File: rtl/phase_sawtooth_det.sv
module phase_sawtooth_det
    import phd_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ref_i,
    input  logic        fb_i,
    output logic        state_o,
    output logic [CW:0] err_o,
    output logic        err_vld_o
);

    localparam int unsigned NIN = 2;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] rise;
    edge_pair_t     edges;

    assign raw_in = {ref_i, fb_i};

    for (genvar g = 0; g < NIN; g++) begin : g_sync
        phd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .din_i  (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    assign edges.ref_rise = rise[1];
    assign edges.fb_rise  = rise[0];

    phd_state u_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .edges_i (edges),
        .state_o (state_o)
    );

    phd_meter #(.CW(CW)) u_meter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ref_rise_i (edges.ref_rise),
        .state_i    (state_o),
        .err_o      (err_o),
        .err_vld_o  (err_vld_o)
    );

endmodule

// File: tb/sim_phase_sawtooth_det.sv
module sim_phase_sawtooth_det;

    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_s = 1'b0;
    logic        fb_s = 1'b0;
    logic        state;
    logic [CW:0] err;
    logic        vld;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phase_sawtooth_det #(.CW(CW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s),
        .state_o(state), .err_o(err), .err_vld_o(vld)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_s = 1'b0; fb_s = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 state in reset", state, 0);
        check("R1 valid in reset", vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after reset", err, 0);
    endtask

    // Drive periodic edges; check every strobe after the first.
    task automatic run_case(string req, int per, int lag, int hw, int nper, int exp_word);
        int total = per * nper;
        int nv = 0;
        bit state_seen = 0;
        for (int t = 0; t < total + 12; t++) begin
            int tf = t - lag;
            ref_s = (t < total) && ((t % per) < hw);
            fb_s  = (t < total) && (tf >= 0) && ((tf % per) < hw);
            @(negedge clk);
            if (state) state_seen = 1;
            if (vld) begin
                nv++;
                if (nv > 1) check(req, $signed(err), exp_word);
            end
        end
        check({req, " strobe count R5"}, nv, nper - 1);
        if (lag == 0) check("R3 state never high on tie", state_seen, 0);
    endtask

    task automatic test_latency();
        do_reset();
        ref_s = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 state before set latency", state, 0);
        @(negedge clk);
        check("R2 state set after three clocks", state, 1);
        fb_s = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 state before clear latency", state, 1);
        @(negedge clk);
        check("R2 state cleared after three clocks", state, 0);
        ref_s = 1'b0; fb_s = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 no strobe on first edge", vld, 0);
    endtask

    initial begin
        do_reset();
        test_latency();
        do_reset(); run_case("R4 lag 10 of 40", 40, 10, 20, 6, -10);
        do_reset(); run_case("R4 lag 30 of 40", 40, 30, 20, 6, 10);
        do_reset(); run_case("R4 odd period 37 lag 5", 37, 5, 15, 6, -13);
        do_reset(); run_case("R3 zero lag", 40, 0, 20, 5, -20);
        do_reset(); run_case("R6 narrow pulses", 40, 10, 3, 5, -10);
        do_reset(); run_case("R6 wide pulses", 40, 10, 33, 5, -10);
        do_reset(); run_case("R7 lag just under period", 40, 39, 20, 5, 19);
        do_reset(); run_case("R7 lag wrapped past period", 40, 41, 20, 6, -19);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule